// File: doc/BRIEF.md
# Retransmit Window Descriptor Manager

This block keeps the bookkeeping for a sender that must deliver data reliably over a lossy link while holding only a small window of packets. The window has a fixed number of slots (32 by default). Each slot holds a set number and three flags: valid (holds data ready to go), sent (has gone out at least once) and confirmed (the far end has acknowledged it).

A data producer fills slots in index order through a fill handshake. The block tells it which slot and which set number to use. A scan pointer sweeps the slots cyclically, one per cycle, and offers every valid, unconfirmed slot to the frame formatter through a transmit handshake. Each offer is flagged as a retransmission if the slot has already been sent. Acknowledgements carry a slot index and a set number, and they confirm a slot only when both match. A tail pointer walks past confirmed slots and frees them, so the producer can reuse each index for the next set.

Offers happen only after a start command. A stop command withdraws any offer in the same cycle.

Top module: `rwd_manager`

## Requirements
- R1: After reset every slot is invalid. The head, the tail and the fill set number are 0, the block is not running, `tx_valid_o` is 0 and `fill_ready_o` is 1.
- R2: A fill handshake (`fill_valid_i` and `fill_ready_o` both high) stores the set number `fill_set_o` into slot `fill_slot_o`. It marks that slot valid, not sent and not confirmed. The head (`fill_slot_o`, `head_o`) then steps to the next index and wraps from the last index to 0.
- R3: The fill set number `fill_set_o` increments by one, modulo 2^SET_W, on each fill handshake made at the last slot index.
- R4: `fill_ready_o` is high exactly when the slot at the head is invalid. A slot still held in the window cannot be overwritten.
- R5: `start_i` makes the block run from the next cycle. `stop_i` forces `tx_valid_o` low in the same cycle and stops the block from the next cycle. When both are high, stop wins. While the block is not running, no slot is offered.
- R6: While running, the scan pointer visits slot indices in ascending cyclic order, one per cycle. It offers a slot (`tx_valid_o`, `tx_slot_o`, `tx_set_o`) when that slot is valid and not confirmed. It holds its position while an offer waits without `tx_ready_i`.
- R7: `tx_retx_o` is 1 when the offered slot has been sent before. A transmit handshake marks the slot as sent.
- R8: An acknowledgement (`ack_valid_i`, `ack_slot_i`, `ack_set_i`) confirms a slot only if that slot is valid and its stored set number equals `ack_set_i`. A stale or mismatched acknowledgement changes nothing. A confirmed slot is not offered again.
- R9: When the slot at the tail is valid and confirmed, it is released (made invalid) and the tail (`tail_o`) steps forward by one, at most one slot per cycle.
- R10: A valid slot that is still unconfirmed is offered again on every later sweep, as a retransmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command, acts at once |
| running_o | output | 1 | Block is running |
| fill_valid_i | input | 1 | Producer has the next packet ready |
| fill_ready_o | output | 1 | Head slot is free |
| fill_slot_o | output | IDX_W | Slot index for the next fill |
| fill_set_o | output | SET_W | Set number for the next fill |
| tx_valid_o | output | 1 | A slot is offered for transmission |
| tx_ready_i | input | 1 | Formatter takes the offered slot |
| tx_slot_o | output | IDX_W | Offered slot index |
| tx_set_o | output | SET_W | Set number of the offered slot |
| tx_retx_o | output | 1 | Offered slot was sent before |
| ack_valid_i | input | 1 | Acknowledgement strobe |
| ack_slot_i | input | IDX_W | Acknowledged slot index |
| ack_set_i | input | SET_W | Acknowledged set number |
| head_o | output | IDX_W | Head pointer (next slot to fill) |
| tail_o | output | IDX_W | Tail pointer (oldest slot held) |

## Verification
The assertions assume that the producer drives `fill_valid_i` with no precondition, and that acknowledgements may name any slot and any set number, valid or not. They rely only on the handshakes being sampled at the clock edge. The stimulus therefore keeps every input legal at all times. It mixes matching and stale acknowledgements, sporadic start and stop commands and irregular backpressure, and it steers acknowledgements toward slots whose stored set is known, so that both the matching and the stale outcomes occur often.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  typedef enum logic {
    RUN_OFF = 1'b0,
    RUN_ON  = 1'b1
  } run_e;
endpackage

// File: rtl/rwd_ring_ptr.sv
module rwd_ring_ptr #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (step_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/rwd_slot.sv
module rwd_slot #(
  parameter int IDX   = 0,
  parameter int IDX_W = 5,
  parameter int SET_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_we_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic             tx_mark_i,
  input  logic             release_i,
  input  logic             ack_valid_i,
  input  logic [IDX_W-1:0] ack_slot_i,
  input  logic [SET_W-1:0] ack_set_i,
  output logic             valid_o,
  output logic             sent_o,
  output logic             conf_o,
  output logic [SET_W-1:0] set_o
);
  logic             valid_q, sent_q, conf_q;
  logic [SET_W-1:0] set_q;
  logic             ack_hit;

  assign ack_hit = ack_valid_i && (ack_slot_i == IDX_W'(IDX)) && valid_q && (ack_set_i == set_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sent_q  <= 1'b0;
      conf_q  <= 1'b0;
      set_q   <= '0;
    end else if (fill_we_i) begin
      valid_q <= 1'b1;
      sent_q  <= 1'b0;
      conf_q  <= 1'b0;
      set_q   <= fill_set_i;
    end else begin
      if (release_i) valid_q <= 1'b0;
      if (tx_mark_i) sent_q  <= 1'b1;
      if (ack_hit)   conf_q  <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign sent_o  = sent_q;
  assign conf_o  = conf_q;
  assign set_o   = set_q;

  AST_FILL_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_i |-> !valid_q); // R4
  AST_CONF_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conf_q) |-> $past(valid_q)); // R8
  AST_RELEASE_CONFIRMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> (valid_q && conf_q)); // R9
endmodule

// File: rtl/rwd_scan.sv
module rwd_scan
  import rwd_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DEPTH-1:0] elig_i,
  input  logic             tx_ready_i,
  output logic             running_o,
  output logic             tx_valid_o,
  output logic             tx_fire_o,
  output logic [IDX_W-1:0] scan_idx_o
);
  run_e             run_q;
  logic             step;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= RUN_OFF;
    else if (stop_i)  run_q <= RUN_OFF;
    else if (start_i) run_q <= RUN_ON;
  end

  assign tx_valid_o = (run_q == RUN_ON) && !stop_i && elig_i[idx];
  assign tx_fire_o  = tx_valid_o && tx_ready_i;
  // advance unless an offer is stalled
  assign step       = (run_q == RUN_ON) && !(tx_valid_o && !tx_ready_i);

  rwd_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .idx_o  (idx)
  );

  assign running_o  = (run_q == RUN_ON);
  assign scan_idx_o = idx;

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> $stable(idx)); // R6
  AST_STOP_BLOCKS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !tx_valid_o); // R5
  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !running_o); // R5
endmodule

// File: rtl/rwd_manager.sv
module rwd_manager #(
  parameter int DEPTH = 32,
  parameter int SET_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             running_o,
  input  logic             fill_valid_i,
  output logic             fill_ready_o,
  output logic [IDX_W-1:0] fill_slot_o,
  output logic [SET_W-1:0] fill_set_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [IDX_W-1:0] tx_slot_o,
  output logic [SET_W-1:0] tx_set_o,
  output logic             tx_retx_o,
  input  logic             ack_valid_i,
  input  logic [IDX_W-1:0] ack_slot_i,
  input  logic [SET_W-1:0] ack_set_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0] valid_v, sent_v, conf_v, elig_v;
  logic [SET_W-1:0] set_a [DEPTH];
  logic [IDX_W-1:0] head, tail, scan;
  logic [SET_W-1:0] head_set_q;
  logic             fill_fire, rel, tx_fire;

  assign fill_ready_o = !valid_v[head];
  assign fill_fire    = fill_valid_i && fill_ready_o;
  assign rel          = valid_v[tail] && conf_v[tail];
  assign elig_v       = valid_v & ~conf_v;

  rwd_ring_ptr #(.DEPTH(DEPTH)) u_head (
    .clk_i (clk_i), .rst_ni (rst_ni), .step_i (fill_fire), .idx_o (head)
  );

  rwd_ring_ptr #(.DEPTH(DEPTH)) u_tail (
    .clk_i (clk_i), .rst_ni (rst_ni), .step_i (rel), .idx_o (tail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        head_set_q <= '0;
    else if (fill_fire && head == LAST) head_set_q <= head_set_q + 1'b1;
  end

  rwd_scan #(.DEPTH(DEPTH)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .elig_i     (elig_v),
    .tx_ready_i (tx_ready_i),
    .running_o  (running_o),
    .tx_valid_o (tx_valid_o),
    .tx_fire_o  (tx_fire),
    .scan_idx_o (scan)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rwd_slot #(.IDX(i), .IDX_W(IDX_W), .SET_W(SET_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_we_i   (fill_fire && head == IDX_W'(i)),
      .fill_set_i  (head_set_q),
      .tx_mark_i   (tx_fire && scan == IDX_W'(i)),
      .release_i   (rel && tail == IDX_W'(i)),
      .ack_valid_i (ack_valid_i),
      .ack_slot_i  (ack_slot_i),
      .ack_set_i   (ack_set_i),
      .valid_o     (valid_v[i]),
      .sent_o      (sent_v[i]),
      .conf_o      (conf_v[i]),
      .set_o       (set_a[i])
    );
  end

  assign fill_slot_o = head;
  assign fill_set_o  = head_set_q;
  assign tx_slot_o   = scan;
  assign tx_set_o    = set_a[scan];
  assign tx_retx_o   = sent_v[scan];
  assign head_o      = head;
  assign tail_o      = tail;

  AST_HEAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_fire |=> head == (($past(head) == LAST) ? '0 : IDX_W'($past(head) + 1'b1))); // R2
  AST_SET_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_fire && head == LAST) |=> fill_set_o == SET_W'($past(fill_set_o) + 1'b1)); // R3
  AST_TX_IS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (valid_v[tx_slot_o] && !conf_v[tx_slot_o])); // R8
endmodule

// File: tb/sim_rwd_manager.sv
module sim_rwd_manager;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int SET_W = 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic b_start = 0, b_stop = 0, b_fv = 0, b_rdy = 0, b_av = 0;
  logic [IDX_W-1:0] b_as = '0;
  logic [SET_W-1:0] b_aset = '0;

  logic running_o, fill_ready_o, tx_valid_o, tx_retx_o;
  logic [IDX_W-1:0] fill_slot_o, tx_slot_o, head_o, tail_o;
  logic [SET_W-1:0] fill_set_o, tx_set_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rwd_manager #(.DEPTH(DEPTH), .SET_W(SET_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(b_start), .stop_i(b_stop),
    .running_o(running_o), .fill_valid_i(b_fv), .fill_ready_o(fill_ready_o),
    .fill_slot_o(fill_slot_o), .fill_set_o(fill_set_o), .tx_valid_o(tx_valid_o),
    .tx_ready_i(b_rdy), .tx_slot_o(tx_slot_o), .tx_set_o(tx_set_o),
    .tx_retx_o(tx_retx_o), .ack_valid_i(b_av), .ack_slot_i(b_as),
    .ack_set_i(b_aset), .head_o(head_o), .tail_o(tail_o)
  );

  // reference state, built from the requirements
  bit mv [DEPTH], ms [DEPTH], mc [DEPTH];
  int mset [DEPTH];
  int mhead = 0, mtail = 0, mhset = 0, msc = 0;
  bit mrun = 0;
  int n_cmp = 0, n_bad = 0, n_pres = 0, n_retx = 0;
  bit done = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  // one clock: compare outputs against the model, update the model, advance
  task automatic cycle();
    bit e_ready, e_txv, fire_fill, rel, fire_tx, hit;
    #1;
    e_ready = !mv[mhead];
    e_txv   = mrun && !b_stop && mv[msc] && !mc[msc];
    chk(running_o == mrun, "R5 running", running_o, mrun);
    chk(fill_ready_o == e_ready, "R4 fill_ready", fill_ready_o, e_ready);
    chk(fill_slot_o == mhead, "R2 fill_slot", fill_slot_o, mhead);
    chk(head_o == mhead, "R2 head", head_o, mhead);
    chk(fill_set_o == SET_W'(mhset), "R3 fill_set", fill_set_o, mhset % (1 << SET_W));
    chk(tail_o == mtail, "R9 tail", tail_o, mtail);
    chk(tx_valid_o == e_txv, "R6 tx_valid", tx_valid_o, e_txv);
    if (e_txv) begin
      chk(tx_slot_o == msc, "R6 tx_slot", tx_slot_o, msc);
      chk(tx_set_o == SET_W'(mset[msc]), "R6 tx_set", tx_set_o, mset[msc]);
      chk(tx_retx_o == ms[msc], "R7 tx_retx", tx_retx_o, ms[msc]);
      n_pres++;
      if (ms[msc]) n_retx++;
    end
    fire_fill = b_fv && e_ready;
    rel       = mv[mtail] && mc[mtail];
    fire_tx   = e_txv && b_rdy;
    hit       = b_av && mv[b_as] && (SET_W'(mset[b_as]) == b_aset);
    if (fire_tx) ms[msc] = 1;
    if (hit) mc[b_as] = 1;
    if (rel) begin
      mv[mtail] = 0;
      mtail = (mtail + 1) % DEPTH;
    end
    if (fire_fill) begin
      mv[mhead] = 1; ms[mhead] = 0; mc[mhead] = 0; mset[mhead] = mhset % (1 << SET_W);
      if (mhead == DEPTH - 1) mhset++;
      mhead = (mhead + 1) % DEPTH;
    end
    if (mrun && !(e_txv && !b_rdy)) msc = (msc + 1) % DEPTH;
    if (b_stop) mrun = 0;
    else if (b_start) mrun = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; ms[i] = 0; mc[i] = 0; mset[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(running_o == 0, "R1 running", running_o, 0);
    chk(tx_valid_o == 0, "R1 tx_valid", tx_valid_o, 0);
    chk(fill_ready_o == 1, "R1 fill_ready", fill_ready_o, 1);
    chk(head_o == 0 && tail_o == 0, "R1 pointers", head_o + tail_o, 0);
    chk(fill_set_o == 0, "R1 fill_set", fill_set_o, 0);

    // fill the whole window while stopped
    b_fv = 1;
    repeat (DEPTH + 1) cycle();
    b_fv = 0;
    #1 chk(fill_ready_o == 0, "R4 full window blocks fill", fill_ready_o, 0);

    // start, first sweep: all new
    b_start = 1; cycle(); b_start = 0;
    b_rdy = 1; n_pres = 0; n_retx = 0;
    repeat (DEPTH) cycle();
    chk(n_pres == DEPTH && n_retx == 0, "R7 first sweep new", n_retx, 0);
    // second sweep: all retransmissions
    n_pres = 0; n_retx = 0;
    repeat (DEPTH) cycle();
    chk(n_retx == DEPTH, "R10 second sweep retransmits", n_retx, DEPTH);

    // confirm odd slots, one stale ack to slot 2
    b_rdy = 0;
    for (int i = 1; i < DEPTH; i += 2) begin
      b_av = 1; b_as = IDX_W'(i); b_aset = '0; cycle();
    end
    b_as = 2; b_aset = 1; cycle();
    b_av = 0; b_rdy = 1;
    n_pres = 0;
    repeat (DEPTH) cycle();
    chk(n_pres == DEPTH / 2, "R8 only unconfirmed offered", n_pres, DEPTH / 2);
    chk(tail_o == 0, "R9 tail waits on slot 0", tail_o, 0);

    // confirm the rest, release and refill with the next set
    b_rdy = 0;
    for (int i = 0; i < DEPTH; i += 2) begin
      b_av = 1; b_as = IDX_W'(i); b_aset = '0; cycle();
    end
    b_av = 0; b_fv = 1;
    repeat (3 * DEPTH) cycle();
    b_fv = 0;
    #1;
    chk(fill_set_o == 2, "R3 set after second wrap", fill_set_o, 2);
    chk(tail_o == 0 && head_o == 0, "R9 tail wrapped", tail_o, 0);

    // pseudo-random mix
    for (int n = 0; n < 6000; n++) begin
      lf_step();
      b_fv    = lf[0] | lf[5];
      b_rdy   = lf[1] | lf[7];
      b_start = (lf[4:2] == 3'b101);
      b_stop  = (lf[10:6] == 5'b00000);
      b_av    = lf[11];
      b_as    = IDX_W'(lf[15:11] ^ lf[4:0]);
      b_aset  = SET_W'(mset[lf[15:11] ^ lf[4:0]] - (lf[9] & lf[8]));
      cycle();
    end
    finish_run();
  end
endmodule